// File: doc/BRIEF.md
# Indirect Auto-Increment Register Port

This block is the host-side register front end of a small bus-interface controller. The host sees only two byte-wide locations, chosen by `host_sel`. At location 0 a write loads an internal register pointer, and a read returns a live auxiliary status byte. At location 1 the host reads or writes whichever of the 26 internal byte registers the pointer selects. After each such access the pointer steps forward by one, so a multi-byte field such as the 24-bit transfer count loads with one pointer write followed by back-to-back data writes.

The block builds the auxiliary status byte from its own flags and from the core's live strobes. It blocks register access while the core reports busy or command in progress. It hands each accepted command to the core as a one-cycle pulse. It latches status bytes posted by the core and raises a pending interrupt that a read of the status register clears.

A two-state access machine governs read responses. In `ACC_IDLE` no read data is valid. Any read strobe that has no write strobe with it moves the machine to `ACC_RESP`, where `host_rvalid` is high and `host_rdata` holds the captured byte. A further read strobe keeps the machine in `ACC_RESP`. A cycle with no read strobe returns it to `ACC_IDLE`.

Top module: `idx_regport`

## Requirements
- R1: After reset the pointer is 0, all 26 registers are 0, `host_rvalid` and `cmd_valid` are 0, and the auxiliary byte has its interrupt and ignored-command flags clear.
- R2: A location-0 write loads the pointer from the written byte, and any value above 25 selects register 25. A location-0 read returns the auxiliary byte and leaves the pointer unchanged.
- R3: An accepted location-1 access reaches register[pointer], and then the pointer increments when it is below 25. Registers 18, 19 and 20 hold `xfer_count` bits 23:16, 15:8 and 7:0 respectively.
- R4: With the pointer at 25 (data), location-1 accesses leave the pointer at 25.
- R5: Auxiliary byte layout: bit 7 interrupt pending, bit 6 last command ignored, bit 5 `core_busy`, bit 4 `core_cip`, bit 1 `core_perr`, bit 0 `core_dbr`. Bits 3:2 read 0.
- R6: While `core_busy` is 1, a location-1 access with the pointer other than 24 or 25 is blocked: a write changes nothing, a read returns 0x00, and the pointer does not move.
- R7: A write to register 24 while `core_cip` is 1 is discarded and sets the ignored-command flag. A write to register 24 while `core_cip` is 0 is accepted, clears that flag and pulses `cmd_valid` one cycle, with `cmd_code` = bits 6:0 and `cmd_single` = bit 7. Any access to register 24 during `core_cip` leaves the pointer unmoved, and a read of it returns 0x00.
- R8: `core_irq` loads `core_status` into register 23 and sets interrupt pending. An accepted read of register 23 clears interrupt pending. When `core_irq` and that read fall in the same cycle, the read returns the old status and the pending flag stays set.
- R9: Read data is in `host_rdata` with `host_rvalid` high in the cycle after the read strobe. If `host_wr` and `host_rd` are both high, the write is performed and the read is dropped.
- R10: `sync_offset` is register 17 bits 3:0, and `sync_period` is register 17 bits 6:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 0 = pointer/auxiliary location, 1 = register data location |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Captured read byte |
| host_rvalid | output | 1 | Read byte valid |
| core_busy | input | 1 | Core busy |
| core_cip | input | 1 | Core command in progress |
| core_perr | input | 1 | Core parity error flag |
| core_dbr | input | 1 | Core data buffer ready |
| core_irq | input | 1 | One-cycle status post strobe |
| core_status | input | 8 | Status byte posted with `core_irq` |
| cmd_valid | output | 1 | One-cycle pulse per accepted command |
| cmd_code | output | 7 | Command code |
| cmd_single | output | 1 | Single-byte transfer qualifier |
| xfer_count | output | 24 | Transfer count |
| sync_offset | output | 4 | Synchronous offset field |
| sync_period | output | 3 | Synchronous period code |

## Verification
Two functions can act on the status path in one cycle: the core posting a status with `core_irq`, and the host's clearing read of register 23. The bench provokes this collision on purpose in a directed step, and again by chance in the random phase. It judges the result by the byte the read returns, which must be the old status. It then reads the auxiliary byte, where the pending bit must still be set, and reads register 23 again, which must return the new status. A host command write that meets `core_cip` is the second collision, and it is judged through `cmd_valid` and the ignored-command bit.

// File: rtl/regport_pkg.sv
package regport_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 26;
    localparam int PTR_W    = $clog2(NUM_REGS);
    localparam int CNT_W    = 3 * BYTE_W;

    localparam logic [PTR_W-1:0] IDX_SYNC    = PTR_W'(17);
    localparam logic [PTR_W-1:0] IDX_CNT_HI  = PTR_W'(18);
    localparam logic [PTR_W-1:0] IDX_CNT_MID = PTR_W'(19);
    localparam logic [PTR_W-1:0] IDX_CNT_LO  = PTR_W'(20);
    localparam logic [PTR_W-1:0] IDX_STATUS  = PTR_W'(23);
    localparam logic [PTR_W-1:0] IDX_CMD     = PTR_W'(24);
    localparam logic [PTR_W-1:0] IDX_LAST    = PTR_W'(NUM_REGS - 1);

    localparam int AUX_INT  = 7;
    localparam int AUX_LCI  = 6;
    localparam int AUX_BSY  = 5;
    localparam int AUX_CIP  = 4;
    localparam int AUX_PERR = 1;
    localparam int AUX_DBR  = 0;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_t;
endpackage

// File: rtl/regport_ptr.sv
module regport_ptr
    import regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              step,
    output logic [PTR_W-1:0]  ptr
);
    localparam logic [BYTE_W-1:0] LAST_B = BYTE_W'(NUM_REGS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= (load_val > LAST_B) ? IDX_LAST : load_val[PTR_W-1:0];
        end else if (step && ptr != IDX_LAST) begin
            ptr <= ptr + 1'b1;
        end
    end

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && ptr == IDX_LAST) |=> ptr == IDX_LAST);

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && ptr != IDX_LAST) |=> ptr == $past(ptr) + 1'b1);
endmodule

// File: rtl/regport_regfile.sv
module regport_regfile
    import regport_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [PTR_W-1:0]                wr_idx,
    input  logic [BYTE_W-1:0]               wr_data,
    input  logic                            stat_ld,
    input  logic [BYTE_W-1:0]               stat_val,
    output logic [NUM_REGS-1:0][BYTE_W-1:0] regs
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [PTR_W-1:0] MY_IDX = PTR_W'(g);
        if (MY_IDX == IDX_STATUS) begin : g_status
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= '0;
                else if (stat_ld)
                    regs[g] <= stat_val;
                else if (wr_en && wr_idx == MY_IDX)
                    regs[g] <= wr_data;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= '0;
                else if (wr_en && wr_idx == MY_IDX)
                    regs[g] <= wr_data;
            end
        end
    end

    // R8
    stat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_ld |=> regs[IDX_STATUS] == $past(stat_val));
endmodule

// File: rtl/regport_aux.sv
module regport_aux
    import regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_set,
    input  logic              int_clr,
    input  logic              cmd_acc,
    input  logic              cmd_ign,
    input  logic              busy,
    input  logic              cip,
    input  logic              perr,
    input  logic              dbr,
    output logic [BYTE_W-1:0] aux
);
    logic int_pend;
    logic lci;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_pend <= 1'b0;
            lci      <= 1'b0;
        end else begin
            if (irq_set)
                int_pend <= 1'b1;
            else if (int_clr)
                int_pend <= 1'b0;
            if (cmd_ign)
                lci <= 1'b1;
            else if (cmd_acc)
                lci <= 1'b0;
        end
    end

    always_comb begin
        aux           = '0;
        aux[AUX_INT]  = int_pend;
        aux[AUX_LCI]  = lci;
        aux[AUX_BSY]  = busy;
        aux[AUX_CIP]  = cip;
        aux[AUX_PERR] = perr;
        aux[AUX_DBR]  = dbr;
    end

    // R7
    lci_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ign |=> lci);

    // R8
    int_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> int_pend);

    // R8
    int_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clr && !irq_set) |=> !int_pend);
endmodule

// File: rtl/idx_regport.sv
module idx_regport
    import regport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_sel,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        host_rvalid,
    input  logic        core_busy,
    input  logic        core_cip,
    input  logic        core_perr,
    input  logic        core_dbr,
    input  logic        core_irq,
    input  logic [7:0]  core_status,
    output logic        cmd_valid,
    output logic [6:0]  cmd_code,
    output logic        cmd_single,
    output logic [23:0] xfer_count,
    output logic [3:0]  sync_offset,
    output logic [2:0]  sync_period
);
    acc_state_t state_q, state_d;

    logic [PTR_W-1:0]                ptr;
    logic [NUM_REGS-1:0][BYTE_W-1:0] regs;
    logic [BYTE_W-1:0]               aux;
    logic [BYTE_W-1:0]               rd_mux;
    logic [BYTE_W-1:0]               rdata_q;
    logic                            cmd_valid_q;

    logic rd_go, at_cmd, at_data, blocked;
    logic loc1_acc, accepted, step;
    logic cmd_acc, cmd_ign, int_clr, ptr_load;

    // access decode and gating
    always_comb begin
        rd_go    = host_rd && !host_wr;
        at_cmd   = (ptr == IDX_CMD);
        at_data  = (ptr == IDX_LAST);
        blocked  = (core_busy && !at_cmd && !at_data) || (core_cip && at_cmd);
        loc1_acc = host_sel && (host_wr || rd_go);
        accepted = loc1_acc && !blocked;
        step     = accepted && !at_data;
        ptr_load = !host_sel && host_wr;
        cmd_acc  = accepted && host_wr && at_cmd;
        cmd_ign  = host_sel && host_wr && at_cmd && core_cip;
        int_clr  = accepted && rd_go && (ptr == IDX_STATUS);
        if (!host_sel)
            rd_mux = aux;
        else if (blocked)
            rd_mux = '0;
        else
            rd_mux = regs[ptr];
    end

    regport_ptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (host_wdata),
        .step     (step),
        .ptr      (ptr)
    );

    regport_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accepted && host_wr),
        .wr_idx   (ptr),
        .wr_data  (host_wdata),
        .stat_ld  (core_irq),
        .stat_val (core_status),
        .regs     (regs)
    );

    regport_aux u_aux (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_set (core_irq),
        .int_clr (int_clr),
        .cmd_acc (cmd_acc),
        .cmd_ign (cmd_ign),
        .busy    (core_busy),
        .cip     (core_cip),
        .perr    (core_perr),
        .dbr     (core_dbr),
        .aux     (aux)
    );

    // access machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ACC_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (rd_go) state_d = ACC_RESP;
            ACC_RESP: state_d = rd_go ? ACC_RESP : ACC_IDLE;
        endcase
    end

    // data and pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q     <= '0;
            cmd_valid_q <= 1'b0;
        end else begin
            if (rd_go)
                rdata_q <= rd_mux;
            cmd_valid_q <= cmd_acc;
        end
    end

    // outputs
    always_comb begin
        host_rvalid = (state_q == ACC_RESP);
        host_rdata  = rdata_q;
        cmd_valid   = cmd_valid_q;
        cmd_code    = regs[IDX_CMD][6:0];
        cmd_single  = regs[IDX_CMD][7];
        xfer_count  = {regs[IDX_CNT_HI], regs[IDX_CNT_MID], regs[IDX_CNT_LO]};
        sync_offset = regs[IDX_SYNC][3:0];
        sync_period = regs[IDX_SYNC][6:4];
    end

    // R6
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && host_wr && core_busy && ptr < IDX_CMD) |=> ptr == $past(ptr));

    // R9
    rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr) |=> host_rvalid);

    // R9
    no_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid);

    // R7
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !$past(core_cip));
endmodule

// File: tb/test_idx_regport.sv
`timescale 1ns/1ps
module test_idx_regport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic        core_busy = 1'b0, core_cip = 1'b0, core_perr = 1'b0, core_dbr = 1'b0;
    logic        core_irq = 1'b0;
    logic [7:0]  core_status = '0;
    logic        cmd_valid;
    logic [6:0]  cmd_code;
    logic        cmd_single;
    logic [23:0] xfer_count;
    logic [3:0]  sync_offset;
    logic [2:0]  sync_period;

    always #4 clk = ~clk;

    idx_regport i_idx_regport (.*);

    int checks = 0, failures = 0;
    logic [7:0] m_regs [26];
    int  m_ptr = 0;
    bit  m_int = 0, m_lci = 0;
    logic [7:0] last_rd;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit is_blocked(int p, bit b, bit c);
        return (b && p != 24 && p != 25) || (c && p == 24);
    endfunction

    function automatic logic [7:0] exp_aux(bit b, bit c, bit pe, bit db);
        return {m_int, m_lci, b, c, 2'b00, pe, db};
    endfunction

    // one host cycle, optional core status post in the same cycle
    task automatic op(input bit sel, input bit wr, input bit rd, input logic [7:0] d,
                      input bit irq, input logic [7:0] st, input string req);
        bit rgo, blk, cv;
        logic [7:0] er;
        rgo = rd && !wr;
        blk = is_blocked(m_ptr, core_busy, core_cip);
        cv = 0;
        er = 8'h00;
        if (rgo) begin
            if (!sel) er = exp_aux(core_busy, core_cip, core_perr, core_dbr);
            else if (!blk) er = m_regs[m_ptr];
        end
        @(negedge clk);
        host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = d;
        core_irq = irq; core_status = st;
        @(negedge clk);
        host_wr = 0; host_rd = 0; core_irq = 0;
        // model update
        if (wr && !sel) begin
            m_ptr = (d > 25) ? 25 : int'(d);
        end else if (sel && (wr || rgo)) begin
            if (wr && m_ptr == 24 && core_cip) m_lci = 1;
            if (!blk) begin
                if (wr) begin
                    m_regs[m_ptr] = d;
                    if (m_ptr == 24) begin m_lci = 0; cv = 1; end
                end else if (m_ptr == 23) m_int = 0;
                if (m_ptr != 25) m_ptr++;
            end
        end
        if (irq) begin m_int = 1; m_regs[23] = st; end
        chk({req, " R9 rvalid"}, 32'(host_rvalid), 32'(rgo));
        if (rgo) begin
            chk({req, " rdata"}, 32'(host_rdata), 32'(er));
            last_rd = host_rdata;
        end
        chk({req, " R7 cmd_valid"}, 32'(cmd_valid), 32'(cv));
        if (cv) chk({req, " R7 cmd fields"}, {24'd0, cmd_single, cmd_code}, 32'(d));
        chk({req, " R3 xfer_count"}, 32'(xfer_count), {8'd0, m_regs[18], m_regs[19], m_regs[20]});
    endtask

    task automatic wr0(input logic [7:0] d, input string r); op(0, 1, 0, d, 0, 0, r); endtask
    task automatic wr1(input logic [7:0] d, input string r); op(1, 1, 0, d, 0, 0, r); endtask
    task automatic rd0(input string r); op(0, 0, 1, 0, 0, 0, r); endtask
    task automatic rd1(input string r); op(1, 0, 1, 0, 0, 0, r); endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures + 0);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 26; i++) m_regs[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rvalid", 32'(host_rvalid), 0);
        chk("R1 cmd_valid", 32'(cmd_valid), 0);
        chk("R1 count", 32'(xfer_count), 0);
        rd0("R1 aux");
        chk("R1 aux literal", 32'(last_rd), 0);
        rd1("R1 reg0");
        chk("R1 reg0 literal", 32'(last_rd), 0);

        // R3 count fill, MSB first
        wr0(8'd18, "R3"); wr1(8'h12, "R3"); wr1(8'h34, "R3"); wr1(8'h56, "R3");
        chk("R3 count literal", 32'(xfer_count), 32'h123456);
        wr0(8'd18, "R3"); wr1(8'hFF, "R3"); wr1(8'hFF, "R3"); wr1(8'hFF, "R3");
        chk("R3 count max", 32'(xfer_count), 32'hFFFFFF);

        // R10 sync fields
        wr0(8'd17, "R10"); wr1(8'hDA, "R10");
        chk("R10 offset", 32'(sync_offset), 32'hA);
        chk("R10 period", 32'(sync_period), 32'h5);

        // R4 data streaming and R2 clamp
        wr0(8'd25, "R4"); wr1(8'h11, "R4"); wr1(8'h22, "R4"); wr1(8'h33, "R4");
        rd1("R4 data"); chk("R4 data literal", 32'(last_rd), 32'h33);
        wr0(8'd200, "R2 clamp"); rd1("R2 clamp"); chk("R2 clamp literal", 32'(last_rd), 32'h33);

        // R2 location-0 read leaves the pointer
        wr0(8'd5, "R2"); wr1(8'h77, "R2"); wr0(8'd5, "R2"); rd0("R2"); rd1("R2");
        chk("R2 ptr kept literal", 32'(last_rd), 32'h77);

        // R5 aux layout
        core_busy = 1; core_cip = 1; core_perr = 1; core_dbr = 1;
        rd0("R5 aux");
        chk("R5 aux literal", 32'(last_rd), 32'h33);
        core_busy = 0; core_cip = 0; core_perr = 0; core_dbr = 0;

        // R6 busy gating
        wr0(8'd2, "R6"); core_busy = 1;
        wr1(8'h99, "R6 write"); rd1("R6 read");
        chk("R6 read zero", 32'(last_rd), 0);
        core_busy = 0; rd1("R6 after");
        chk("R6 reg unchanged", 32'(last_rd), 0);
        rd1("R6 ptr advanced once");

        // R7 command ignored then accepted
        wr0(8'd24, "R7"); core_cip = 1; wr1(8'h85, "R7 ign");
        rd0("R7 aux"); chk("R7 lci set", 32'(last_rd[6]), 1);
        core_cip = 0; wr1(8'h85, "R7 acc");
        rd0("R7 aux2"); chk("R7 lci clear", 32'(last_rd[6]), 0);

        // R8 interrupt set, clear on read, collision
        op(0, 0, 0, 0, 1, 8'h42, "R8 post");
        rd0("R8 aux"); chk("R8 int set", 32'(last_rd[7]), 1);
        wr0(8'd23, "R8"); rd1("R8 read"); chk("R8 status", 32'(last_rd), 32'h42);
        rd0("R8 aux"); chk("R8 int clr", 32'(last_rd[7]), 0);
        op(0, 0, 0, 0, 1, 8'h42, "R8 post2");
        wr0(8'd23, "R8"); op(1, 0, 1, 0, 1, 8'h16, "R8 collide");
        chk("R8 collide old", 32'(last_rd), 32'h42);
        rd0("R8 collide aux"); chk("R8 int kept", 32'(last_rd[7]), 1);
        wr0(8'd23, "R8"); rd1("R8 new"); chk("R8 new status", 32'(last_rd), 32'h16);

        // R9 simultaneous write and read
        wr0(8'd10, "R9"); op(1, 1, 1, 8'h5C, 0, 0, "R9 both");
        wr0(8'd10, "R9"); rd1("R9 check"); chk("R9 write won", 32'(last_rd), 32'h5C);

        // random phase
        for (int n = 0; n < 600; n++) begin
            bit s, w, ir;
            logic [7:0] d;
            core_busy = ($urandom % 4) == 0;
            core_cip  = ($urandom % 8) == 0;
            core_perr = $urandom % 2;
            core_dbr  = $urandom % 2;
            s = $urandom % 4 != 0;
            w = $urandom % 2;
            ir = ($urandom % 16) == 0;
            d = 8'($urandom);
            if (!s && w) d = 8'($urandom % 28);
            op(s, w, !w, d, ir, 8'($urandom), "R6 random");
        end
        core_busy = 0; core_cip = 0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule